// File: doc/BRIEF.md
# Transmit Channel Credit and Status Unit

This unit keeps the control state and health flags for a group of transmit DMA channels. It does not move any data. Each channel holds a small configuration word that sets an operating mode and an internal-request enable. Each channel also holds a one-entry command buffer, loaded by an activation strobe from a scheduler and emptied by a completion strobe. A credit counter tracks how many words the channel may still place into its downstream transmit FIFO. A channel raises its DMA request only when it is allowed to run, holds a command and has credit left.

A shared status word gives two flags per channel: "buffers empty" (all credit returned) and "no pending request" (command buffer empty). A channel that has been switched off is idle once both flags read 1. A shared error word collects four kinds of fault. The first is a credit mismatch, where the FIFO reports full while credit remains. The second is a double activation, where a command arrives while the buffer still holds the previous one. The last two are a local address error and a host dword shortfall. Every error bit is sticky and is cleared only when software writes 1 to it.

Top module: `txch_status`

## Requirements
- R1: After reset every configuration is 0, every credit counter equals CREDIT_MAX, every command buffer is empty, error_o is 0, dma_req is 0 and status_o reads 0xFFFF0000 for eight channels.
- R2: Configuration bits 31:30 select the mode: 00 off, 01 pause at end of frame, 10 run, 11 treated as off. Bit 3 enables internal requests. In run mode, dma_req for a channel is 1 exactly when bit 3 is set, the command buffer is full and credit is nonzero.
- R3: When a channel enters pause-at-end-of-frame while it holds a command, it keeps requesting for that command until the command completes. A command loaded afterwards does not raise a request while the mode stays 01.
- R4: Credit drops by one for each pushed word and rises by one for each drain pulse. A push and a drain in the same cycle leave it unchanged. It saturates at 0 and at CREDIT_MAX.
- R5: status_o bit 24+n is 1 when channel n's credit equals CREDIT_MAX. Bit 16+n is 1 when its command buffer is empty. All other status bits read 0.
- R6: error_o bit n sets when fifo_full[n] is 1 while channel n's credit is nonzero. A full indication at zero credit sets nothing.
- R7: error_o bit 9+n sets when an activation for channel n arrives while its buffer is full and no completion comes in the same cycle. An activation together with a completion replaces the command with no error.
- R8: error_o bit 31 sets on addr_err and bit 30 sets on dw_short. Bits 8 and 29:17 always read 0.
- R9: Error bits stay set until a clear write carries a 1 in that position. Clear writes with 0 in a position leave that bit unchanged.
- R10: If a set event and a clear write hit the same error bit in one cycle, the bit ends set.
- R11: Writing 0 to a channel's configuration drops its dma_req on the next cycle. Its pending flag stays 0 until the held command completes.
- R12: Strobes and configuration writes for one channel change no other channel's credit, request, status or error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | $clog2(NCH) | Channel selected by the configuration write |
| cfg_wdata | input | 32 | Configuration word (bits 31:30 mode, bit 3 request enable) |
| err_clr_we | input | 1 | Error clear write strobe |
| err_clr_data | input | 32 | Error bits to clear (write 1 to clear) |
| act_cmd | input | NCH | Per-channel activation command strobe |
| cmd_done | input | NCH | Per-channel command completion strobe |
| word_push | input | NCH | Per-channel word pushed into the FIFO |
| word_drain | input | NCH | Per-channel word drained from the FIFO |
| fifo_full | input | NCH | Per-channel FIFO full indication |
| addr_err | input | 1 | Internal memory address error event |
| dw_short | input | 1 | Host dword shortfall event |
| dma_req | output | NCH | Per-channel internal DMA request |
| credit_o | output | NCH*CW | Packed per-channel credit counters |
| status_o | output | 32 | Shared status word |
| error_o | output | 32 | Shared sticky error word |

## Verification
The bench builds the unit with the full eight channels, so every status and error field position is exercised. CREDIT_MAX is lowered to 4, so the bench can reach both saturation ends of the credit counter in a few strobes. It can also show the request being gated by zero credit and the full-at-zero-credit case that must not raise a mismatch. The mode changes run against a held command, so the end-of-frame latch, switch-off and idle detection are all reached.

// File: rtl/txcs_pkg.sv
package txcs_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_EOF  = 2'b01,
    MODE_RUN  = 2'b10,
    MODE_RSVD = 2'b11
  } chmode_e;

  // configuration field positions
  localparam int CFG_MODE_LSB = 30;
  localparam int CFG_REQEN    = 3;

  // status field bases
  localparam int ST_EMPTY_BASE  = 24;
  localparam int ST_NOPEND_BASE = 16;

  // error field bases
  localparam int ER_CREDIT_BASE = 0;
  localparam int ER_DBLACT_BASE = 9;
  localparam int ER_ADDR_BIT    = 31;
  localparam int ER_DWSHORT_BIT = 30;

  // next credit value: push consumes, drain returns, both saturate
  function automatic int credit_step(input int cur, input bit push,
                                     input bit drain, input int max);
    if (push && !drain) return (cur > 0) ? cur - 1 : 0;
    if (drain && !push) return (cur < max) ? cur + 1 : max;
    return cur;
  endfunction

  // implemented error bits for a given channel count
  function automatic logic [31:0] err_mask(input int nch);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < nch; i++) begin
      m[ER_CREDIT_BASE + i] = 1'b1;
      m[ER_DBLACT_BASE + i] = 1'b1;
    end
    m[ER_ADDR_BIT]    = 1'b1;
    m[ER_DWSHORT_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/txcs_chan.sv
module txcs_chan
  import txcs_pkg::*;
#(
  parameter int CREDIT_MAX = 16,
  parameter int CW = $clog2(CREDIT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_reqen,
  input  logic          act,
  input  logic          done,
  input  logic          push,
  input  logic          drain,
  input  logic          full,
  output logic          dma_req,
  output logic [CW-1:0] credit,
  output logic          buf_empty,
  output logic          no_pend,
  output logic          ev_credit_err,
  output logic          ev_dblact
);

  localparam logic [CW-1:0] CMAX = CW'(CREDIT_MAX);

  chmode_e       mode_q;
  logic          reqen_q;
  logic          trb_q;
  logic          hold_q;
  logic [CW-1:0] credit_q;

  chmode_e       mode_new;
  logic          hold_d;
  logic          running;
  logic          credit_nz;

  assign mode_new  = chmode_e'(cfg_mode);
  assign credit_nz = (credit_q != '0);

  // end-of-frame latch: remembers the command in flight when pausing
  always_comb begin
    hold_d = hold_q;
    if (done)
      hold_d = 1'b0;
    else if (cfg_we)
      hold_d = (mode_new == MODE_EOF) &&
               ((mode_q == MODE_EOF) ? hold_q : trb_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_OFF;
      reqen_q  <= 1'b0;
      trb_q    <= 1'b0;
      hold_q   <= 1'b0;
      credit_q <= CMAX;
    end else begin
      if (cfg_we) begin
        mode_q  <= mode_new;
        reqen_q <= cfg_reqen;
      end
      if (act)       trb_q <= 1'b1;
      else if (done) trb_q <= 1'b0;
      hold_q   <= hold_d;
      credit_q <= CW'(credit_step(int'(credit_q), push, drain, CREDIT_MAX));
    end
  end

  assign running = reqen_q &&
                   ((mode_q == MODE_RUN) || ((mode_q == MODE_EOF) && hold_q));

  assign dma_req       = running && trb_q && credit_nz;
  assign credit        = credit_q;
  assign buf_empty     = (credit_q == CMAX);
  assign no_pend       = !trb_q;
  assign ev_credit_err = full && credit_nz;
  assign ev_dblact     = act && trb_q && !done;

  a_r4_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= CMAX);

  a_r4_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !drain && credit_nz) |=> (credit_q == $past(credit_q) - 1'b1));

  a_r4_drain_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !push && (credit_q != CMAX)) |=> (credit_q == $past(credit_q) + 1'b1));

  a_r11_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_mode == 2'b00)) |=> !dma_req);

  a_r3_eof_new_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_EOF) && !cfg_we && !trb_q && act) |=> !dma_req);

endmodule

// File: rtl/txcs_errreg.sv
module txcs_errreg #(
  parameter int          W    = 32,
  parameter logic [31:0] MASK = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_d;

  // set has priority over write-1 clear
  assign q_d = ((q_r & ~clr_vec) | set_vec) & MASK[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & MASK[W-1:0])) |=> ((q_r & $past(set_vec & MASK[W-1:0])) == $past(set_vec & MASK[W-1:0])));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|(q_r & ~clr_vec)) |=> ((q_r & $past(q_r & ~clr_vec)) == $past(q_r & ~clr_vec)));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((q_r & $past(clr_vec & ~set_vec)) == '0));

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r & ~MASK[W-1:0]) == '0);

endmodule

// File: rtl/txch_status.sv
module txch_status
  import txcs_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int CREDIT_MAX = 16,
  parameter int SELW       = $clog2(NCH),
  parameter int CW         = $clog2(CREDIT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SELW-1:0]   cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              err_clr_we,
  input  logic [31:0]       err_clr_data,
  input  logic [NCH-1:0]    act_cmd,
  input  logic [NCH-1:0]    cmd_done,
  input  logic [NCH-1:0]    word_push,
  input  logic [NCH-1:0]    word_drain,
  input  logic [NCH-1:0]    fifo_full,
  input  logic              addr_err,
  input  logic              dw_short,
  output logic [NCH-1:0]    dma_req,
  output logic [NCH*CW-1:0] credit_o,
  output logic [31:0]       status_o,
  output logic [31:0]       error_o
);

  localparam logic [31:0] EMASK = err_mask(NCH);

  logic [NCH-1:0] ch_we;
  logic [NCH-1:0] ch_empty;
  logic [NCH-1:0] ch_nopend;
  logic [NCH-1:0] ev_credit;
  logic [NCH-1:0] ev_dbl;
  logic [31:0]    err_set;
  logic [31:0]    err_clr;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign ch_we[g] = cfg_we && (cfg_sel == SELW'(g));

      txcs_chan #(.CREDIT_MAX(CREDIT_MAX), .CW(CW)) u_chan (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (ch_we[g]),
        .cfg_mode      (cfg_wdata[CFG_MODE_LSB +: 2]),
        .cfg_reqen     (cfg_wdata[CFG_REQEN]),
        .act           (act_cmd[g]),
        .done          (cmd_done[g]),
        .push          (word_push[g]),
        .drain         (word_drain[g]),
        .full          (fifo_full[g]),
        .dma_req       (dma_req[g]),
        .credit        (credit_o[g*CW +: CW]),
        .buf_empty     (ch_empty[g]),
        .no_pend       (ch_nopend[g]),
        .ev_credit_err (ev_credit[g]),
        .ev_dblact     (ev_dbl[g])
      );
    end
  endgenerate

  always_comb begin
    status_o = '0;
    err_set  = '0;
    for (int i = 0; i < NCH; i++) begin
      status_o[ST_EMPTY_BASE + i]  = ch_empty[i];
      status_o[ST_NOPEND_BASE + i] = ch_nopend[i];
      err_set[ER_CREDIT_BASE + i]  = ev_credit[i];
      err_set[ER_DBLACT_BASE + i]  = ev_dbl[i];
    end
    err_set[ER_ADDR_BIT]    = addr_err;
    err_set[ER_DWSHORT_BIT] = dw_short;
  end

  assign err_clr = err_clr_we ? err_clr_data : '0;

  txcs_errreg #(.W(32), .MASK(EMASK)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (err_set),
    .clr_vec (err_clr),
    .q       (error_o)
  );

  a_r12_one_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_we));

endmodule

// File: tb/sim_txch_status.sv
module sim_txch_status;

  localparam int NCH = 8;
  localparam int CMAX = 4;
  localparam int CW = $clog2(CMAX + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic err_clr_we = 0;
  logic [31:0] err_clr_data = 0;
  logic [NCH-1:0] act_cmd = 0, cmd_done = 0, word_push = 0, word_drain = 0, fifo_full = 0;
  logic addr_err = 0, dw_short = 0;
  logic [NCH-1:0] dma_req;
  logic [NCH*CW-1:0] credit_o;
  logic [31:0] status_o, error_o;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  txch_status #(.NCH(NCH), .CREDIT_MAX(CMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .err_clr_we(err_clr_we), .err_clr_data(err_clr_data), .act_cmd(act_cmd),
    .cmd_done(cmd_done), .word_push(word_push), .word_drain(word_drain),
    .fifo_full(fifo_full), .addr_err(addr_err), .dw_short(dw_short),
    .dma_req(dma_req), .credit_o(credit_o), .status_o(status_o), .error_o(error_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cred(input int ch);
    return 32'(credit_o[ch*CW +: CW]);
  endfunction

  // all strobes are applied for one clock, results read at the next negedge
  task automatic step();
    @(negedge clk);
    cfg_we = 0; err_clr_we = 0; err_clr_data = 0;
    act_cmd = 0; cmd_done = 0; word_push = 0; word_drain = 0; fifo_full = 0;
    addr_err = 0; dw_short = 0;
  endtask

  task automatic wcfg(input int ch, input logic [31:0] v);
    cfg_we = 1; cfg_sel = 3'(ch); cfg_wdata = v; step();
  endtask

  task automatic clr_err(input logic [31:0] v);
    err_clr_we = 1; err_clr_data = v; step();
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 32'hFFFF_0000);
    chk("R1 error", error_o, 32'h0);
    chk("R1 dma_req", 32'(dma_req), 32'h0);
    for (int c = 0; c < NCH; c++) chk("R1 credit", cred(c), CMAX);
  endtask

  task automatic t_credit();
    word_push[0] = 1; step();
    chk("R4 push", cred(0), 3);
    chk("R5 empty flag", status_o[24 +: 8], 8'hFE);
    chk("R12 other credit", cred(1), CMAX);
    word_push[0] = 1; word_drain[0] = 1; step();
    chk("R4 push+drain", cred(0), 3);
    for (int i = 0; i < 5; i++) begin word_push[0] = 1; step(); end
    chk("R4 floor", cred(0), 0);
    word_drain[0] = 1; step();
    chk("R4 drain", cred(0), 1);
    for (int i = 0; i < 6; i++) begin word_drain[0] = 1; step(); end
    chk("R4 ceiling", cred(0), CMAX);
    chk("R5 empty back", status_o, 32'hFFFF_0000);
  endtask

  task automatic t_run();
    wcfg(1, 32'h8000_0008);
    chk("R2 no cmd no req", 32'(dma_req), 0);
    act_cmd[1] = 1; step();
    chk("R2 run req", 32'(dma_req), 32'h2);
    chk("R5 pending", status_o, 32'hFFFD_0000);
    wcfg(1, 32'h8000_0000);
    chk("R2 reqen off", 32'(dma_req), 0);
    wcfg(1, 32'h8000_0008);
    for (int i = 0; i < CMAX; i++) begin word_push[1] = 1; step(); end
    chk("R2 zero credit", 32'(dma_req), 0);
    word_drain[1] = 1; step();
    chk("R2 credit back", 32'(dma_req), 32'h2);
    wcfg(1, 32'hC000_0008);
    chk("R2 mode 11 off", 32'(dma_req), 0);
    cmd_done[1] = 1; step();
    for (int i = 0; i < CMAX; i++) begin word_drain[1] = 1; step(); end
    chk("R5 ch1 idle", status_o, 32'hFFFF_0000);
  endtask

  task automatic t_eof();
    wcfg(2, 32'h8000_0008);
    act_cmd[2] = 1; step();
    wcfg(2, 32'h4000_0008);
    chk("R3 held cmd requests", 32'(dma_req), 32'h4);
    cmd_done[2] = 1; step();
    chk("R3 done ends", 32'(dma_req), 0);
    act_cmd[2] = 1; step();
    chk("R3 new cmd no req", 32'(dma_req), 0);
    chk("R3 pending", status_o[18], 1'b0);
    wcfg(2, 32'h0);
    cmd_done[2] = 1; step();
  endtask

  task automatic t_off();
    wcfg(3, 32'h8000_0008);
    act_cmd[3] = 1; step();
    chk("R11 running", 32'(dma_req), 32'h8);
    wcfg(3, 32'h0);
    chk("R11 req drops", 32'(dma_req), 0);
    chk("R11 not idle", {31'h0, status_o[27] & status_o[19]}, 0);
    cmd_done[3] = 1; step();
    chk("R11 idle", {31'h0, status_o[27] & status_o[19]}, 1);
  endtask

  task automatic t_credit_err();
    fifo_full[4] = 1; step();
    chk("R6 mismatch", error_o, 32'h0000_0010);
    for (int i = 0; i < CMAX; i++) begin word_push[4] = 1; step(); end
    clr_err(32'h10);
    fifo_full[4] = 1; step();
    chk("R6 full at zero", error_o, 32'h0);
    for (int i = 0; i < CMAX; i++) begin word_drain[4] = 1; step(); end
  endtask

  task automatic t_dblact();
    act_cmd[5] = 1; step();
    chk("R7 first act", error_o, 32'h0);
    act_cmd[5] = 1; step();
    chk("R7 double act", error_o, 32'h0000_4000);
    clr_err(32'hFFFF_FFFF);
    act_cmd[5] = 1; cmd_done[5] = 1; step();
    chk("R7 act with done", error_o, 32'h0);
    chk("R7 still pending", status_o[21], 1'b0);
    cmd_done[5] = 1; step();
  endtask

  task automatic t_global();
    addr_err = 1; step();
    chk("R8 addr", error_o, 32'h8000_0000);
    dw_short = 1; step();
    chk("R8 dwshort", error_o, 32'hC000_0000);
    clr_err(32'h0);
    chk("R9 zero write", error_o, 32'hC000_0000);
    clr_err(32'h8000_0000);
    chk("R9 selective", error_o, 32'h4000_0000);
    addr_err = 1; err_clr_we = 1; err_clr_data = 32'hC000_0000; step();
    chk("R10 set wins", error_o, 32'h8000_0000);
    clr_err(32'hFFFF_FFFF);
    chk("R9 all clear", error_o, 32'h0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_credit();
    t_run();
    t_eof();
    t_off();
    t_credit_err();
    t_dblact();
    t_global();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule